// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This unit keeps two counters for a processor core. A 64-bit time base counts up without stopping. A 32-bit decrementer counts down. Both move one step for each cycle in which the tick-enable input is high, and that input stands for the time-base frequency. Software reaches the counters through single-cycle register strobes. It can read or write the lower time-base word, the upper time-base word and the decrementer. Reads are combinational and have no wait states.

The decrementer raises a timer interrupt request whenever its sign bit goes from clear to set. This happens in two ways: the count passes through zero, or software writes a negative value over a non-negative one. The request is sticky. Only a dedicated acknowledge strobe clears it.

The unit has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. A write strobe always takes effect in the cycle it is presented.

Top module: `tbdec_timer`

## Requirements
- R1: After reset the time base reads zero in both words, the decrementer reads 0xFFFFFFFF and the interrupt request is low.
- R2: The time base increments by one on every cycle with tick high, and the carry propagates from the lower word into the upper word. It holds its value when tick is low.
- R3: A write with select 0 replaces time-base bits 31:0 and keeps the current bits 63:32.
- R4: A write with select 1 replaces time-base bits 63:32 and keeps the current bits 31:0.
- R5: The decrementer drops by one on every cycle with tick high and holds its value otherwise. A write with select 2 loads it.
- R6: A tick when the decrementer is zero wraps it to 0xFFFFFFFF and raises the interrupt request.
- R7: A decrementer write raises the request only if the new value has bit 31 set and the value just before the write had bit 31 clear.
- R8: Writing zero to the decrementer does not expire it in the write cycle, even if tick is high in that cycle. The expiry comes on the next tick.
- R9: The interrupt request stays high until the acknowledge strobe is pulsed. An acknowledge with no new event clears it.
- R10: If an acknowledge and a new decrementer event occur in the same cycle, the request is left high.
- R11: A write in a tick cycle takes priority over that tick for the register written. The other counter still steps on that tick.
- R12: The read select uses the same encoding as the write select: 0 for the lower word, 1 for the upper word, 2 for the decrementer. The read data shows the current value in the same cycle. Select 3 reads zero, and a write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base step enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written (0 low word, 1 high word, 2 decrementer) |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Register read (same encoding) |
| rd_data | output | 32 | Current value of the selected register |
| irq_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Sticky timer interrupt request |

## Verification
The hardest case to reach is a collision at the zero crossing. In that case the decrementer event lands in the same cycle as an acknowledge, or in the same cycle as a write. Counting down from reset to zero would take billions of ticks. The stimulus therefore writes small values such as 3 or 0 into the decrementer, and then steps single ticks until the count is exactly zero. In the crossing cycle it applies tick together with the acknowledge or the write. Carry into the upper word is reached the same way: the lower word is written to 0xFFFFFFFF and then one tick is applied.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
  typedef enum logic [1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W-1:0]   wr_data,
  output logic [2*W-1:0] tb
);
  localparam int TW = 2 * W;

  always_ff @(posedge clk) begin
    if (!rst_n)     tb <= '0;
    else if (wr_lo) tb <= {tb[TW-1:W], wr_data};
    else if (wr_hi) tb <= {wr_data, tb[W-1:0]};
    else if (tick)  tb <= tb + {{(TW-1){1'b0}}, 1'b1};
  end

  AST_TB_INC: assert property (@(posedge clk) disable iff (!rst_n) // R2
    (tick && !wr_lo && !wr_hi) |=> tb == $past(tb) + {{(TW-1){1'b0}}, 1'b1});
  AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R2
    (!tick && !wr_lo && !wr_hi) |=> $stable(tb));
  AST_TB_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n) // R3
    wr_lo |=> tb[TW-1:W] == $past(tb[TW-1:W]));
  AST_TB_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n) // R4
    (wr_hi && !wr_lo) |=> tb[W-1:0] == $past(tb[W-1:0]));
endmodule

// File: rtl/tbdec_decr.sv
module tbdec_decr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic         evt
);
  logic sw_neg;
  logic wrap;

  assign sw_neg = wr_data[W-1] & ~cnt[W-1];
  assign wrap   = tick & (cnt == '0);
  assign evt    = wr ? sw_neg : wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '1;
    else if (wr)   cnt <= wr_data;
    else if (tick) cnt <= cnt - {{(W-1){1'b0}}, 1'b1};
  end

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n) // R5
    (tick && !wr) |=> cnt == $past(cnt) - {{(W-1){1'b0}}, 1'b1});
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R5
    (!tick && !wr) |=> $stable(cnt));
  AST_DEC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) // R11
    wr |=> cnt == $past(wr_data));
  AST_DEC_WRAP_EVT: assert property (@(posedge clk) disable iff (!rst_n) // R6
    (evt && !wr) |=> cnt == '1);
endmodule

// File: rtl/tbdec_irq_flag.sv
module tbdec_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (ack) irq <= 1'b0;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) // R9
    (irq && !ack) |=> irq);
  AST_IRQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) // R9
    (ack && !set) |=> !irq);
  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) // R10
    set |=> irq);
endmodule

// File: rtl/tbdec_timer.sv
module tbdec_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         irq_ack,
  output logic         irq
);
  import tbdec_pkg::*;
  localparam int TW = 2 * W;

  logic [TW-1:0] tb;
  logic [W-1:0]  dec;
  logic          dec_evt;
  logic          wr_lo, wr_hi, wr_dec;

  assign wr_lo  = wr_en && (reg_sel_e'(wr_sel) == SEL_TB_LO);
  assign wr_hi  = wr_en && (reg_sel_e'(wr_sel) == SEL_TB_HI);
  assign wr_dec = wr_en && (reg_sel_e'(wr_sel) == SEL_DEC);

  tbdec_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .tb(tb)
  );

  tbdec_decr #(.W(W)) u_dec (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr(wr_dec), .wr_data(wr_data), .cnt(dec), .evt(dec_evt)
  );

  tbdec_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set(dec_evt), .ack(irq_ack), .irq(irq)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_TB_LO: rd_data = tb[W-1:0];
      SEL_TB_HI: rd_data = tb[TW-1:W];
      SEL_DEC:   rd_data = dec;
      default:   rd_data = '0;
    endcase
  end

  AST_RESERVED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) // R12
    (wr_en && reg_sel_e'(wr_sel) == SEL_NONE && !tick) |=> ($stable(tb) && $stable(dec)));
  AST_WRITE_NONNEG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) // R7
    (wr_dec && !wr_data[W-1] && !irq) |=> !irq);
endmodule

// File: tb/test_tbdec_timer.sv
`timescale 1ns/1ps
module test_tbdec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        irq_ack = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbdec_timer i_tbdec_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_ack(irq_ack), .irq(irq)
  );

  // vector: {wr, sel[1:0], data[31:0], tick, ack, rsel[1:0], exp[31:0], eirq}
  localparam int NV = 15;
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 2'd0, 32'h1,        1'b0}, // R2 tick
    {1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 2'd2, 32'hFFFFFFFD, 1'b0}, // R5
    {1'b1, 2'd2, 32'h3,        1'b0, 1'b0, 2'd2, 32'h3,        1'b0}, // R5 load
    {1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 2'd0, 32'h3,        1'b0}, // R2
    {1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 2'd2, 32'h1,        1'b0}, // R5
    {1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 2'd2, 32'h0,        1'b0}, // R6 at zero
    {1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 2'd2, 32'hFFFFFFFF, 1'b1}, // R6 wrap
    {1'b0, 2'd0, 32'h0,        1'b0, 1'b1, 2'd0, 32'h6,        1'b0}, // R9 ack
    {1'b1, 2'd1, 32'h12345678, 1'b1, 1'b0, 2'd1, 32'h12345678, 1'b0}, // R4 R11
    {1'b0, 2'd0, 32'h0,        1'b0, 1'b0, 2'd0, 32'h6,        1'b0}, // R4 low kept
    {1'b1, 2'd0, 32'hFFFFFFFF, 1'b0, 1'b0, 2'd1, 32'h12345678, 1'b0}, // R3
    {1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 2'd1, 32'h12345679, 1'b0}, // R2 carry
    {1'b0, 2'd0, 32'h0,        1'b0, 1'b0, 2'd0, 32'h0,        1'b0}, // R2 hold
    {1'b1, 2'd3, 32'hAAAA5555, 1'b0, 1'b0, 2'd3, 32'h0,        1'b0}, // R12
    {1'b0, 2'd0, 32'h0,        1'b0, 1'b0, 2'd2, 32'hFFFFFFFD, 1'b0}  // R12 no effect
  };

  task automatic step(input logic w, input logic [1:0] s, input logic [31:0] d,
                      input logic t, input logic a);
    @(negedge clk);
    wr_en = w; wr_sel = s; wr_data = d; tick = t; irq_ack = a;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tick = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic check_rd(input logic [1:0] s, input logic [31:0] exp, input string req);
    rd_sel = s;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_sel=%0d rd_data=%h expected %h", req, s, rd_data, exp);
    end
  endtask

  task automatic check_irq(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", req, irq, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check_rd(2'd0, 32'h0, "R1");
    check_rd(2'd1, 32'h0, "R1");
    check_rd(2'd2, 32'hFFFFFFFF, "R1");
    check_irq(1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][71], VEC[i][70:69], VEC[i][68:37], VEC[i][36], VEC[i][35]);
      check_rd(VEC[i][34:33], VEC[i][32:1], $sformatf("vector %0d", i));
      check_irq(VEC[i][0], $sformatf("vector %0d", i));
    end

    // R7: negative written over non-negative raises the request
    step(1'b1, 2'd2, 32'h5, 1'b0, 1'b0);
    step(1'b1, 2'd2, 32'h80000000, 1'b0, 1'b0);
    check_irq(1'b1, "R7");
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    check_irq(1'b0, "R9");
    // R7: negative over negative does not
    step(1'b1, 2'd2, 32'h80000001, 1'b0, 1'b0);
    check_irq(1'b0, "R7");
    check_rd(2'd2, 32'h80000001, "R7");

    // R8/R11: zero written during a tick, no expiry, time base still steps
    check_rd(2'd0, 32'h0, "R11");
    step(1'b1, 2'd2, 32'h0, 1'b1, 1'b0);
    check_rd(2'd2, 32'h0, "R8");
    check_irq(1'b0, "R8");
    check_rd(2'd0, 32'h1, "R11");
    step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
    check_rd(2'd2, 32'hFFFFFFFF, "R8");
    check_irq(1'b1, "R8");

    // R10: ack while wrap occurs with request already high
    step(1'b1, 2'd2, 32'h0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 32'h0, 1'b1, 1'b1);
    check_irq(1'b1, "R10");
    // R10: ack with request low, coinciding with a software event
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    check_irq(1'b0, "R9");
    step(1'b1, 2'd2, 32'h0, 1'b0, 1'b0);
    step(1'b1, 2'd2, 32'hF0000000, 1'b0, 1'b1);
    check_irq(1'b1, "R10");

    // R1: reset in the middle of activity
    do_reset();
    check_rd(2'd0, 32'h0, "R1");
    check_rd(2'd2, 32'hFFFFFFFF, "R1");
    check_irq(1'b0, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule